// File: doc/BRIEF.md
# Pulse-Width Transponder Write Encoder

This block writes a low-frequency transponder by keying the reader field on and off. After a start strobe it keeps the field on for a long charging interval. It then transmits a fixed 112-bit frame in which every bit occupies one constant bit period. The value of each bit is carried only by the length of the field-off gap at the start of that period. After the last bit the field stays on for a programming hold, and then the block reports completion.

All intervals are counted in microseconds. A prescaler derives the microsecond tick from the system clock, and a parameter sets how many clocks make one microsecond. The CRC word comes from the user when one is supplied. Otherwise the block uses a checksum that an external generator has already computed over the data word.

Top module: `pw_write_encoder`

## Requirements
- R1: After reset, and whenever no operation is running, `fieldOnO` is 1, `busyO` is 0 and `doneO` is 0.
- R2: A start strobe taken while idle raises `busyO` and keeps the field on for CHARGE_US × CLK_PER_US clocks, counted from the clock edge that samples the strobe. Every later interval is likewise its microsecond length × CLK_PER_US clocks.
- R3: A 1 bit is a field-off gap of ONE_OFF_US followed by field-on for BIT_US − ONE_OFF_US.
- R4: A 0 bit is a field-off gap of ZERO_OFF_US followed by field-on for BIT_US − ZERO_OFF_US.
- R5: The frame is 112 bits in this byte order: 0xBB, 0xEB, the data word from its least to its most significant byte, the CRC low byte, the CRC high byte, 0x00, 0x03.
- R6: Each byte goes out least significant bit first. The first eight bits sent are therefore 1,1,0,1,1,1,0,1.
- R7: When the last bit's field-on part ends, the field stays on for a further PROG_US. Then `busyO` falls, and `doneO` is 1 for exactly the one clock in which `busyO` is first 0.
- R8: When `userCrcValidI` is 1 and `userCrcI` is nonzero, `userCrcI` is sent verbatim as the CRC.
- R9: When `userCrcValidI` is 0, or `userCrcI` is zero, `dataCrcI` is sent as the CRC.
- R10: A start strobe that arrives while `busyO` is 1 has no effect on the frame being sent or on its timing.
- R11: Data and CRC inputs are captured when the start is accepted. Later changes to them do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startI | input | 1 | One-clock start strobe |
| dataI | input | 64 | Data word to write |
| userCrcI | input | 16 | User-supplied CRC |
| userCrcValidI | input | 1 | 1 when userCrcI is supplied |
| dataCrcI | input | 16 | Checksum precomputed from dataI |
| fieldOnO | output | 1 | Reader field enable (1 = field on) |
| busyO | output | 1 | Operation in progress |
| doneO | output | 1 | One-clock completion pulse |

## Verification
The hardest case to reach from the ports is a second start strobe that lands in the middle of a frame, together with changed data and CRC inputs. The design must neither restart nor pick up the new values. The bench raises start partway through bit ten, with all-zero data and CRC on the inputs. It then decodes the whole frame from the measured gap widths and checks it against the first word. It also checks that the final hold length is unchanged.

// File: rtl/pw_write_pkg.sv
package pw_write_pkg;

  localparam logic [7:0]  KEYWORD_BYTE  = 8'hBB;
  localparam logic [7:0]  PASSWORD_BYTE = 8'hEB;
  localparam logic [15:0] WRITE_CMD     = 16'h0300;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHARGE,
    ST_GAP,
    ST_ON,
    ST_PROG
  } wrState_t;

  typedef enum logic [1:0] {
    LIM_CHARGE,
    LIM_GAP,
    LIM_ON,
    LIM_PROG
  } limSel_t;

  typedef struct packed {
    logic    run;
    logic    load;
    logic    clrTime;
    logic    shift;
    limSel_t limSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/pw_write_datapath.sv
module pw_write_datapath
  import pw_write_pkg::*;
#(
  parameter int CLK_PER_US  = 48,
  parameter int CHARGE_US   = 50000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ZERO_OFF_US = 300,
  parameter int BIT_US      = 2000,
  parameter int PROG_US     = 50000,
  parameter int DATA_W      = 64,
  parameter int CRC_W       = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [DATA_W-1:0] dataI,
  input  logic [CRC_W-1:0]  userCrcI,
  input  logic              userCrcValidI,
  input  logic [CRC_W-1:0]  dataCrcI,
  output logic              phaseEnd,
  output logic              curBit,
  output logic              lastBit
);

  localparam int FRAME_BITS = 16 + DATA_W + CRC_W + 16;
  localparam int BITCNT_W   = $clog2(FRAME_BITS);
  localparam int PRE_W      = $clog2(CLK_PER_US + 1);
  localparam int MAX_A      = (CHARGE_US > PROG_US) ? CHARGE_US : PROG_US;
  localparam int MAX_US     = (MAX_A > BIT_US) ? MAX_A : BIT_US;
  localparam int US_W       = $clog2(MAX_US + 1);

  localparam logic [US_W-1:0]  CHARGE_L   = US_W'(CHARGE_US);
  localparam logic [US_W-1:0]  PROG_L     = US_W'(PROG_US);
  localparam logic [US_W-1:0]  ONE_GAP_L  = US_W'(ONE_OFF_US);
  localparam logic [US_W-1:0]  ZERO_GAP_L = US_W'(ZERO_OFF_US);
  localparam logic [US_W-1:0]  ONE_ON_L   = US_W'(BIT_US - ONE_OFF_US);
  localparam logic [US_W-1:0]  ZERO_ON_L  = US_W'(BIT_US - ZERO_OFF_US);
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0]      preCnt;
  logic [US_W-1:0]       usCnt;
  logic [US_W-1:0]       limitUs;
  logic                  usTick;
  logic [FRAME_BITS-1:0] frameSr;
  logic [BITCNT_W-1:0]   bitCnt;
  logic [CRC_W-1:0]      crcSel;

  // Microsecond prescaler and interval counter
  assign usTick = (preCnt == PRE_LAST);

  always_comb begin
    unique case (stb.limSel)
      LIM_CHARGE: limitUs = CHARGE_L;
      LIM_GAP:    limitUs = curBit ? ONE_GAP_L : ZERO_GAP_L;
      LIM_ON:     limitUs = curBit ? ONE_ON_L : ZERO_ON_L;
      default:    limitUs = PROG_L;
    endcase
  end

  assign phaseEnd = stb.run && usTick && (usCnt == limitUs - US_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (stb.clrTime) begin
      preCnt <= '0;
      usCnt  <= '0;
    end else if (stb.run) begin
      preCnt <= usTick ? '0 : preCnt + PRE_W'(1);
      if (usTick) usCnt <= usCnt + US_W'(1);
    end
  end

  // Frame assembly and serialisation
  assign crcSel = (userCrcValidI && (userCrcI != '0)) ? userCrcI : dataCrcI;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSr <= '0;
      bitCnt  <= '0;
    end else if (stb.load) begin
      frameSr <= {WRITE_CMD, crcSel, dataI, PASSWORD_BYTE, KEYWORD_BYTE};
      bitCnt  <= '0;
    end else if (stb.shift) begin
      frameSr <= frameSr >> 1;
      bitCnt  <= bitCnt + BITCNT_W'(1);
    end
  end

  assign curBit  = frameSr[0];
  assign lastBit = (bitCnt == BITCNT_W'(FRAME_BITS - 1));

  // R2
  prescale_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    preCnt <= PRE_LAST);

  // R2
  interval_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.run |-> (usCnt < limitUs));

  // R5
  bit_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.shift |-> (bitCnt < BITCNT_W'(FRAME_BITS - 1)));

endmodule

// File: rtl/pw_write_ctrl.sv
module pw_write_ctrl
  import pw_write_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic        phaseEnd,
  input  logic        lastBit,
  output ctrlStrobe_t stb,
  output logic        fieldOn,
  output logic        busy,
  output logic        done
);

  wrState_t state, nextState;

  always_comb begin
    stb        = '0;
    stb.run    = (state != ST_IDLE);
    nextState  = state;
    stb.limSel = LIM_CHARGE;
    unique case (state)
      ST_IDLE: begin
        if (startI) begin
          stb.load    = 1'b1;
          stb.clrTime = 1'b1;
          nextState   = ST_CHARGE;
        end
      end
      ST_CHARGE: begin
        stb.limSel = LIM_CHARGE;
        if (phaseEnd) begin
          stb.clrTime = 1'b1;
          nextState   = ST_GAP;
        end
      end
      ST_GAP: begin
        stb.limSel = LIM_GAP;
        if (phaseEnd) begin
          stb.clrTime = 1'b1;
          nextState   = ST_ON;
        end
      end
      ST_ON: begin
        stb.limSel = LIM_ON;
        if (phaseEnd) begin
          stb.clrTime = 1'b1;
          if (lastBit) begin
            nextState = ST_PROG;
          end else begin
            stb.shift = 1'b1;
            nextState = ST_GAP;
          end
        end
      end
      ST_PROG: begin
        stb.limSel = LIM_PROG;
        if (phaseEnd) begin
          stb.clrTime = 1'b1;
          nextState   = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      fieldOn <= 1'b1;
      done    <= 1'b0;
    end else begin
      state   <= nextState;
      fieldOn <= (nextState != ST_GAP);
      done    <= (state == ST_PROG) && phaseEnd;
    end
  end

  assign busy = (state != ST_IDLE);

  // R1
  idle_field_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> fieldOn);

  // R7
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startI && !(state == ST_PROG)) |=> busy);

endmodule

// File: rtl/pw_write_encoder.sv
module pw_write_encoder
  import pw_write_pkg::*;
#(
  parameter int CLK_PER_US  = 48,
  parameter int CHARGE_US   = 50000,
  parameter int ONE_OFF_US  = 1000,
  parameter int ZERO_OFF_US = 300,
  parameter int BIT_US      = 2000,
  parameter int PROG_US     = 50000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startI,
  input  logic [63:0] dataI,
  input  logic [15:0] userCrcI,
  input  logic        userCrcValidI,
  input  logic [15:0] dataCrcI,
  output logic        fieldOnO,
  output logic        busyO,
  output logic        doneO
);

  ctrlStrobe_t stb;
  logic        phaseEnd;
  logic        curBit;
  logic        lastBit;

  pw_write_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .startI   (startI),
    .phaseEnd (phaseEnd),
    .lastBit  (lastBit),
    .stb      (stb),
    .fieldOn  (fieldOnO),
    .busy     (busyO),
    .done     (doneO)
  );

  pw_write_datapath #(
    .CLK_PER_US  (CLK_PER_US),
    .CHARGE_US   (CHARGE_US),
    .ONE_OFF_US  (ONE_OFF_US),
    .ZERO_OFF_US (ZERO_OFF_US),
    .BIT_US      (BIT_US),
    .PROG_US     (PROG_US),
    .DATA_W      (64),
    .CRC_W       (16)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .dataI         (dataI),
    .userCrcI      (userCrcI),
    .userCrcValidI (userCrcValidI),
    .dataCrcI      (dataCrcI),
    .phaseEnd      (phaseEnd),
    .curBit        (curBit),
    .lastBit       (lastBit)
  );

endmodule

// File: tb/pw_write_encoder_tb_top.sv
module pw_write_encoder_tb_top;

  localparam int CPU   = 2;
  localparam int CHG   = 20;
  localparam int ONE   = 10;
  localparam int ZERO  = 3;
  localparam int BITP  = 20;
  localparam int PROG  = 20;
  localparam int NBITS = 112;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startI = 1'b0;
  logic [63:0] dataI = '0;
  logic [15:0] userCrcI = '0;
  logic        userCrcValidI = 1'b0;
  logic [15:0] dataCrcI = '0;
  logic        fieldOnO, busyO, doneO;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  pw_write_encoder #(
    .CLK_PER_US(CPU), .CHARGE_US(CHG), .ONE_OFF_US(ONE),
    .ZERO_OFF_US(ZERO), .BIT_US(BITP), .PROG_US(PROG)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startI(startI), .dataI(dataI),
    .userCrcI(userCrcI), .userCrcValidI(userCrcValidI), .dataCrcI(dataCrcI),
    .fieldOnO(fieldOnO), .busyO(busyO), .doneO(doneO)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
      end
    end
  end

  // Sends one frame and measures it; optionally restarts mid-frame (R10, R11)
  task automatic run_frame(input logic [63:0] d, input logic [15:0] uc,
                           input logic uv, input logic [15:0] dc,
                           input logic [15:0] expCrc, input bit disturb);
    logic [NBITS-1:0] expF;
    logic [NBITS-1:0] got;
    int n;
    int gapErr1;
    int gapErr0;
    int onErr;
    int lastHigh;
    expF = {8'h03, 8'h00, expCrc, d, 8'hEB, 8'hBB};
    got = '0;
    gapErr1 = 0;
    gapErr0 = 0;
    onErr = 0;
    lastHigh = 0;
    @(negedge clk);
    dataI = d; userCrcI = uc; userCrcValidI = uv; dataCrcI = dc;
    startI = 1'b1;
    @(posedge clk);
    @(negedge clk);
    startI = 1'b0;
    chk(busyO == 1'b1, "R2 busy after start", 128'(busyO), 128'd1);
    n = 0;
    while (fieldOnO && n < 5000) begin n++; @(negedge clk); end
    // R2 charge interval
    chk(n == CHG * CPU, "R2 charge length", 128'(n), 128'(CHG * CPU));
    for (int i = 0; i < NBITS; i++) begin
      if (disturb && i == 10) begin
        startI = 1'b1; dataI = '0; userCrcI = '0; dataCrcI = '0;
      end
      n = 0;
      while (!fieldOnO && n < 5000) begin n++; @(negedge clk); startI = 1'b0; end
      got[i] = (n == ONE * CPU);
      if (expF[i] && n != ONE * CPU) gapErr1++;
      if (!expF[i] && n != ZERO * CPU) gapErr0++;
      n = 0;
      if (i < NBITS - 1) begin
        while (fieldOnO && n < 5000) begin n++; @(negedge clk); end
        if (n != (BITP - (expF[i] ? ONE : ZERO)) * CPU) onErr++;
      end else begin
        while (busyO && n < 5000) begin n++; @(negedge clk); end
        lastHigh = n;
      end
    end
    // R3 one-bit gaps, R4 zero-bit gaps and on-times
    chk(gapErr1 == 0, "R3 one-bit gap widths", 128'(gapErr1), 128'd0);
    chk(gapErr0 == 0, "R4 zero-bit gap widths", 128'(gapErr0), 128'd0);
    chk(onErr == 0, "R4 bit period on-times", 128'(onErr), 128'd0);
    chk(got[7:0] == 8'hBB, "R6 first byte lsb first", 128'(got[7:0]), 128'hBB);
    chk(got == expF, disturb ? "R10 R11 frame unaffected by restart" : "R5 full frame",
        128'(got), 128'(expF));
    chk(got[95:80] == expCrc, uv && uc != 0 ? "R8 crc verbatim" : "R9 crc from data",
        128'(got[95:80]), 128'(expCrc));
    // R7 last bit on-time plus programming hold
    chk(lastHigh == (BITP - (expF[NBITS-1] ? ONE : ZERO) + PROG) * CPU,
        "R7 programming hold", 128'(lastHigh),
        128'((BITP - (expF[NBITS-1] ? ONE : ZERO) + PROG) * CPU));
    chk(doneO == 1'b1 && busyO == 1'b0, "R7 done with busy low",
        128'({doneO, busyO}), 128'b10);
    @(negedge clk);
    chk(doneO == 1'b0 && fieldOnO == 1'b1, "R7 R1 done single pulse, field idle on",
        128'({doneO, fieldOnO}), 128'b01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fieldOnO == 1'b1 && busyO == 1'b0 && doneO == 1'b0, "R1 state in reset",
        128'({fieldOnO, busyO, doneO}), 128'b100);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(fieldOnO == 1'b1 && busyO == 1'b0 && doneO == 1'b0, "R1 idle after reset",
        128'({fieldOnO, busyO, doneO}), 128'b100);
    run_frame(64'h0123_4567_89AB_CDEF, 16'hBEEF, 1'b1, 16'h1234, 16'hBEEF, 1'b0);
    run_frame(64'h8000_0000_0000_0001, 16'h0000, 1'b1, 16'h5A5A, 16'h5A5A, 1'b0);
    run_frame(64'h0F0F_F0F0_3C3C_C3C3, 16'hFFFF, 1'b0, 16'h00C3, 16'h00C3, 1'b0);
    run_frame(64'hFFFF_FFFF_FFFF_FFFF, 16'h8001, 1'b1, 16'h0000, 16'h8001, 1'b0);
    run_frame(64'hFEDC_BA98_7654_3210, 16'h1111, 1'b1, 16'h2222, 16'h1111, 1'b1);
    repeat (5) @(negedge clk);
    chk(busyO == 1'b0 && fieldOnO == 1'b1, "R1 idle at end",
        128'({busyO, fieldOnO}), 128'b01);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule